// File: doc/BRIEF.md
# Matched-Delay Four-Phase Latch Stage

This block is one data-holding stage of a self-timed pipeline, written as synthesizable logic that runs on a clock. Both of its faces use four-phase, return-to-zero signalling. Upstream raises a request with a data word. The stage does not inspect the data to decide when capture is complete. Instead, a fixed count of ticks stands in for the worst-case settling time plus margin. When that count runs out, the stage does three things on the same edge: it latches the word, raises its upstream acknowledge and raises its downstream request.

The stage accepts a new word only when two things are true. The upstream acknowledge must have gone back low. The downstream side must also be quiet, which means its request is low and the next stage's acknowledge has returned to zero. The delay length is the parameter `DELAY`, which must be at least 1. The word width is the parameter `WIDTH`.

Top module: `hs_delay_stage`

## Requirements
- R1: While reset is asserted and right after it, `up_ack` and `dn_req` are 0 and `dn_data` is all zeros.
- R2: The stage accepts a request on a clock edge where `up_req` is 1, the stage is idle, and both `dn_req` and `dn_ack` are 0. `up_ack` then rises exactly `DELAY` edges after that accepting edge, and stays 0 before then.
- R3: `dn_req` rises on the same edge as `up_ack`. On that edge `dn_data` takes the value `up_data` holds at that edge.
- R4: Once high, `up_ack` stays 1 for as long as `up_req` is 1. On the first edge that sees `up_req` at 0, `up_ack` returns to 0.
- R5: Once high, `dn_req` stays 1 until an edge sees `dn_ack` at 1. It is 0 after that edge.
- R6: While `dn_req` is 1, or `dn_ack` is still 1, a pending `up_req` is not accepted. During that time `up_ack` stays 0 and `dn_data` keeps its old value. Acceptance begins on the first edge where both are 0.
- R7: `dn_data` changes only on an edge where `dn_req` rises.
- R8: A `DELAY` below 1 or a `WIDTH` below 1 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock for the delay counter and the state |
| rst_n | input | 1 | Active-low reset, applied synchronously |
| up_req | input | 1 | Upstream request: a new word is presented |
| up_ack | output | 1 | Upstream acknowledge: the word has been latched |
| up_data | input | WIDTH | Word offered by upstream |
| dn_req | output | 1 | Downstream request: a latched word is on offer |
| dn_ack | input | 1 | Downstream acknowledge: the next stage took the word |
| dn_data | output | WIDTH | Latched word offered downstream |

## Verification
The hardest case to reach is a request that arrives while the downstream side is still busy. It has to be held off across both halves of the downstream return-to-zero: first while `dn_req` is high, and then while `dn_ack` alone is still high. The stimulus completes one transfer and leaves the downstream acknowledge unanswered. It then raises a new request with a different word and waits longer than the delay. Next it raises `dn_ack` and holds it for several cycles after `dn_req` falls. Only after that does it release `dn_ack`. At each step the bench checks that no acknowledge has appeared and that the output word is unchanged. It then counts the edges until the held-off word is finally accepted.

// File: rtl/hs_stage_pkg.sv
package hs_stage_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_HELD = 2'd2
   } in_state_t;
endpackage

// File: rtl/hs_delay_timer.sv
module hs_delay_timer #(
   parameter int DELAY = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic expire
);
   localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY + 1);

   generate
      if (DELAY == 1) begin : g_single
         logic flag_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      flag_q <= 1'b0;
            else if (start)  flag_q <= 1'b1;
            else             flag_q <= 1'b0;
         end
         assign busy   = flag_q;
         assign expire = flag_q;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)          cnt_q <= '0;
            else if (start)      cnt_q <= CW'(DELAY);
            else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
         end
         assign busy   = (cnt_q != 0);
         assign expire = (cnt_q == CW'(1));
      end
   endgenerate

   // R2: the count never stalls before it runs out
   a_r2_timer_runs: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !expire) |=> busy);
   // R2: the count is idle right after it expires
   a_r2_timer_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !start) |=> !busy);
endmodule

// File: rtl/hs_in_ctrl.sv
module hs_in_ctrl
   import hs_stage_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic up_req,
   input  logic out_free,
   input  logic expire,
   output logic start,
   output logic capture,
   output logic up_ack
);
   in_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      start   = 1'b0;
      capture = 1'b0;
      unique case (state_q)
         ST_IDLE: if (up_req && out_free) begin
            start   = 1'b1;
            state_d = ST_WAIT;
         end
         ST_WAIT: if (expire) begin
            capture = 1'b1;
            state_d = ST_HELD;
         end
         ST_HELD: if (!up_req) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign up_ack = (state_q == ST_HELD);

   // R4: the acknowledge holds while the request is still high
   a_r4_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (up_ack && up_req) |=> up_ack);
   // R4: the acknowledge returns to zero after the request does
   a_r4_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (up_ack && !up_req) |=> !up_ack);
   // R6: no acceptance while the output side is busy
   a_r6_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !out_free) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/hs_out_port.sv
module hs_out_port #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [WIDTH-1:0] up_data,
   input  logic             dn_ack,
   output logic             dn_req,
   output logic [WIDTH-1:0] dn_data,
   output logic             out_free
);
   logic             req_q;
   logic [WIDTH-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       req_q <= 1'b0;
      else if (capture) req_q <= 1'b1;
      else if (dn_ack)  req_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       data_q <= '0;
      else if (capture) data_q <= up_data;
   end

   assign dn_req   = req_q;
   assign dn_data  = data_q;
   assign out_free = !req_q && !dn_ack;

   // R5: the output request waits for the downstream acknowledge
   a_r5_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_req && !dn_ack && !capture) |=> dn_req);
   // R6: a capture never overwrites a word still on offer
   a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
      capture |-> !dn_req);
   // R7: the word moves only together with a new request
   a_r7_data_still: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(dn_req) |-> $stable(dn_data));
endmodule

// File: rtl/hs_delay_stage.sv
module hs_delay_stage #(
   parameter int WIDTH = 16,
   parameter int DELAY = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_req,
   output logic             up_ack,
   input  logic [WIDTH-1:0] up_data,
   output logic             dn_req,
   input  logic             dn_ack,
   output logic [WIDTH-1:0] dn_data
);
   // R8: parameter legality
   generate
      if (DELAY < 1) begin : g_bad_delay
         $error("hs_delay_stage: DELAY must be at least 1");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("hs_delay_stage: WIDTH must be at least 1");
      end
   endgenerate

   logic start, capture, expire, busy, out_free;

   hs_delay_timer #(.DELAY(DELAY)) timer_i (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .expire(expire)
   );

   hs_in_ctrl ctrl_i (
      .clk(clk), .rst_n(rst_n), .up_req(up_req), .out_free(out_free),
      .expire(expire), .start(start), .capture(capture), .up_ack(up_ack)
   );

   hs_out_port #(.WIDTH(WIDTH)) port_i (
      .clk(clk), .rst_n(rst_n), .capture(capture), .up_data(up_data),
      .dn_ack(dn_ack), .dn_req(dn_req), .dn_data(dn_data), .out_free(out_free)
   );

   // R3: both sides are told on the same edge
   a_r3_both_sides: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(up_ack) |-> $rose(dn_req));
   // R2: the timer runs only while an acknowledge is pending
   a_r2_no_early_ack: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !up_ack);
endmodule

// File: tb/hs_delay_stage_tb.sv
module hs_delay_stage_tb_top;
   localparam int W = 16;
   localparam int D = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         up_req = 1'b0;
   logic         dn_ack = 1'b0;
   logic [W-1:0] up_data = '0;
   logic         up_ack, dn_req;
   logic [W-1:0] dn_data;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   hs_delay_stage #(.WIDTH(W), .DELAY(D)) dut_i (
      .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_ack(up_ack),
      .up_data(up_data), .dn_req(dn_req), .dn_ack(dn_ack), .dn_data(dn_data)
   );

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // request raised before the accepting edge; check R2 timing and R3 capture
   task automatic push_word(input logic [W-1:0] w);
      up_data = w;
      up_req  = 1'b1;
      for (int i = 0; i < D; i++) begin
         step();
         check(up_ack, 0, "R2 ack low during delay");
      end
      step();
      check(up_ack, 1, "R2 ack after DELAY edges");
      check(dn_req, 1, "R3 dn_req with ack");
      check(dn_data, w, "R3 captured word");
   endtask

   task automatic release_up();
      up_req = 1'b0;
      step();
      check(up_ack, 0, "R4 ack falls after req");
   endtask

   task automatic drain_down();
      dn_ack = 1'b1;
      step();
      check(dn_req, 0, "R5 dn_req falls on ack");
      dn_ack = 1'b0;
      step();
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      step();
      check(up_ack, 0, "R1 up_ack reset");
      check(dn_req, 0, "R1 dn_req reset");
      check(dn_data, 0, "R1 dn_data reset");
      rst_n = 1'b1;
      step();
      check(up_ack, 0, "R1 up_ack after reset");
   endtask

   task automatic t_basic();
      push_word(16'hA5C3);
      up_data = 16'h1111;
      for (int i = 0; i < 3; i++) begin
         step();
         check(up_ack, 1, "R4 ack held with req");
         check(dn_data, 16'hA5C3, "R7 data steady");
      end
      release_up();
      for (int i = 0; i < 2; i++) begin
         step();
         check(dn_req, 1, "R5 dn_req held without ack");
      end
      drain_down();
   endtask

   task automatic t_patterns();
      logic [W-1:0] pats [3] = '{16'h0000, 16'hFFFF, 16'h5AA5};
      for (int k = 0; k < 3; k++) begin
         push_word(pats[k]);
         release_up();
         drain_down();
      end
   endtask

   task automatic t_blocked();
      push_word(16'h1234);
      release_up();
      up_data = 16'hBEEF;
      up_req  = 1'b1;
      for (int i = 0; i < D + 3; i++) begin
         step();
         check(up_ack, 0, "R6 no accept while dn_req high");
         check(dn_data, 16'h1234, "R6 word kept while blocked");
      end
      dn_ack = 1'b1;
      for (int i = 0; i < 3; i++) begin
         step();
         check(dn_req, 0, "R5 dn_req low after ack");
         check(up_ack, 0, "R6 no accept while dn_ack high");
      end
      dn_ack = 1'b0;
      for (int i = 0; i < D; i++) begin
         step();
         check(up_ack, 0, "R6 delay after release");
      end
      step();
      check(up_ack, 1, "R6 accepted once free");
      check(dn_data, 16'hBEEF, "R6 held-off word captured");
      release_up();
      drain_down();
   endtask

   initial begin
      repeat (2) step();
      t_reset();
      t_basic();
      t_patterns();
      t_blocked();
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule